// File: doc/BRIEF.md
# Segment Offset Limit Checker

This block decides, for one memory access at a time, whether the bytes touched by that access lie inside the legal offset range of a segment. The caller presents the segment's raw 20-bit limit field, its granularity, grow-downward and big-default-size attributes, the access width in bytes, the starting offset and a flag telling whether the machine runs in flat 64-bit addressing. A one-cycle strobe qualifies the request.

On the clock edge that samples the strobe, the block registers two results: a fault flag and the scaled limit that was used for the decision. A small two-state controller (state `ST_IDLE`, waiting, and state `ST_REPORT`, result presented) raises a result-valid output for exactly the cycle after each strobe. Transition `IDLE_TO_REPORT` fires on a strobe in `ST_IDLE`. Transition `REPORT_STAY` fires on a strobe in `ST_REPORT`, so back-to-back requests stream. Transition `REPORT_TO_IDLE` fires when no strobe arrives. Descriptor lookup, type rules, privilege rules and paging belong to other blocks.

Top module: `seg_lim_chk`

## Requirements
- R1: With `gran_i` low, `eff_limit_o` equals `raw_lim_i` zero-extended to 32 bits.
- R2: With `gran_i` high, `eff_limit_o` equals `raw_lim_i` shifted left by 12 with bits 11:0 set to one.
- R3: With `grow_down_i` low, an access is legal only when every byte from the offset through its last byte is at or below `eff_limit_o`; otherwise `fault_o` is 1.
- R4: With `grow_down_i` high, an access is legal only when the offset is above `eff_limit_o` and the last byte is at or below the top bound. The top bound is 0000FFFFh when `big_i` is 0 and FFFFFFFFh when `big_i` is 1.
- R5: With `grow_down_i` high, an offset exactly equal to `eff_limit_o` faults.
- R6: With `flat64_i` high, `fault_o` is 0 whatever the other inputs are. `eff_limit_o` is still the scaled limit.
- R7: The last byte is offset plus `acc_bytes_i` minus 1, and an `acc_bytes_i` of 0 counts as one byte. A last byte that passes FFFFFFFFh faults in either direction mode.
- R8: `fault_o` and `eff_limit_o` take a request's results at the first rising edge where `req_i` is high. `rsp_valid_o` is high for exactly the cycle after each such edge, and back-to-back strobes keep it high.
- R9: Reset drives `fault_o`, `eff_limit_o` and `rsp_valid_o` to 0. Without a strobe, `fault_o` and `eff_limit_o` keep their last values while other inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe qualifying all request inputs |
| raw_lim_i | input | 20 | Unscaled limit field |
| gran_i | input | 1 | Limit counts 4 KiB units when high |
| grow_down_i | input | 1 | Segment grows downward when high |
| big_i | input | 1 | Default size flag selecting the 32-bit top bound for a downward segment |
| acc_bytes_i | input | 4 | Access width in bytes, 0 treated as 1 |
| flat64_i | input | 1 | Flat 64-bit addressing, check bypassed |
| offset_i | input | 32 | Offset of the first byte accessed |
| rsp_valid_o | output | 1 | High the cycle after a strobe |
| fault_o | output | 1 | Registered limit violation |
| eff_limit_o | output | 32 | Registered scaled limit |

## Verification
Every result is due one clock after its strobe: the rising edge that samples `req_i` loads `fault_o`, `eff_limit_o` and `rsp_valid_o` together, and there is no other register on the path. The driver changes inputs on falling edges and pushes each expected pair into a queue. A monitor samples on the next falling edge whenever `rsp_valid_o` is high and compares against the queue head, so single and back-to-back requests are matched in order. The hold behaviour and the single-cycle valid pulse are checked on the falling edges after a strobe is withdrawn, while the other inputs keep changing.

// File: rtl/seg_lim_pkg.sv
package seg_lim_pkg;

    // Controller states of the result presenter
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rsp_state_e;

    // Attribute bundle passed between the pieces of the checker
    typedef struct packed {
        logic gran;
        logic grow_down;
        logic big;
        logic flat64;
    } seg_attr_t;

endpackage

// File: rtl/seg_lim_scale.sv
module seg_lim_scale #(
    parameter int RAW_W   = 20,
    parameter int ADDR_W  = 32,
    parameter int GRAN_SH = 12
) (
    input  logic [RAW_W-1:0]  raw_lim,
    input  logic              gran,
    output logic [ADDR_W-1:0] eff_lim
);
    localparam int SCALED_W = RAW_W + GRAN_SH;

    logic [ADDR_W-1:0] fine_lim;
    logic [ADDR_W-1:0] coarse_lim;
    logic [SCALED_W-1:0] shifted;

    // Page-unit form: raw value moved up, vacated bits filled with ones
    always_comb begin
        shifted = {raw_lim, {GRAN_SH{1'b1}}};
    end

    generate
        if (SCALED_W >= ADDR_W) begin : g_trunc
            assign coarse_lim = shifted[ADDR_W-1:0];
        end else begin : g_pad
            assign coarse_lim = {{(ADDR_W-SCALED_W){1'b0}}, shifted};
        end
        if (RAW_W >= ADDR_W) begin : g_fine_trunc
            assign fine_lim = raw_lim[ADDR_W-1:0];
        end else begin : g_fine_pad
            assign fine_lim = {{(ADDR_W-RAW_W){1'b0}}, raw_lim};
        end
    endgenerate

    always_comb begin
        eff_lim = gran ? coarse_lim : fine_lim;
    end

endmodule

// File: rtl/seg_lim_range.sv
module seg_lim_range
    import seg_lim_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 4,
    parameter int SMALL_W = 16
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] acc_bytes,
    input  logic [ADDR_W-1:0] eff_lim,
    input  seg_attr_t         attr,
    output logic              fault
);
    localparam int EXT_W = ADDR_W + 1;

    logic [SIZE_W-1:0] span_m1;
    logic [EXT_W-1:0]  last_ext;
    logic [EXT_W-1:0]  lim_ext;
    logic [EXT_W-1:0]  top_ext;
    logic [ADDR_W-1:0] top_bound;
    logic              up_fault;
    logic              down_fault;

    always_comb begin
        // zero-byte request behaves as a single byte
        span_m1  = (acc_bytes == '0) ? '0 : acc_bytes - 1'b1;
        last_ext = {1'b0, offset} + {{(EXT_W-SIZE_W){1'b0}}, span_m1};
        lim_ext  = {1'b0, eff_lim};
    end

    generate
        if (SMALL_W >= ADDR_W) begin : g_top_full
            assign top_bound = '1;
        end else begin : g_top_sel
            assign top_bound = attr.big ? {ADDR_W{1'b1}}
                                        : {{(ADDR_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
        end
    endgenerate

    always_comb begin
        top_ext    = {1'b0, top_bound};
        // upward segment: last byte beyond limit (carry included)
        up_fault   = last_ext > lim_ext;
        // downward segment: start must exceed limit, end stays under top
        down_fault = ({1'b0, offset} <= lim_ext) || (last_ext > top_ext);
        if (attr.flat64) begin
            fault = 1'b0;
        end else if (attr.grow_down) begin
            fault = down_fault;
        end else begin
            fault = up_fault;
        end
    end

    always_comb begin
        if (!attr.flat64 && attr.grow_down && offset == eff_lim) begin
            assert (fault) else $error("AST_DOWN_EDGE_FAULT"); // R5
        end
    end

endmodule

// File: rtl/seg_lim_ctrl.sv
module seg_lim_ctrl
    import seg_lim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture,
    output logic rsp_valid
);
    rsp_state_e state_q;
    rsp_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req ? ST_REPORT : ST_IDLE;    // IDLE_TO_REPORT
            ST_REPORT: state_d = req ? ST_REPORT : ST_IDLE;    // REPORT_STAY / REPORT_TO_IDLE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        capture   = req;
        rsp_valid = (state_q == ST_REPORT);
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid); // R8
    AST_VALID_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid); // R8

endmodule

// File: rtl/seg_lim_chk.sv
module seg_lim_chk
    import seg_lim_pkg::*;
#(
    parameter int RAW_W   = 20,
    parameter int ADDR_W  = 32,
    parameter int GRAN_SH = 12,
    parameter int SIZE_W  = 4,
    parameter int SMALL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [RAW_W-1:0]  raw_lim_i,
    input  logic              gran_i,
    input  logic              grow_down_i,
    input  logic              big_i,
    input  logic [SIZE_W-1:0] acc_bytes_i,
    input  logic              flat64_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic              rsp_valid_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] eff_limit_o
);
    seg_attr_t         attr;
    logic [ADDR_W-1:0] lim_w;
    logic              fault_w;
    logic              capture;
    logic              fault_q;
    logic [ADDR_W-1:0] lim_q;

    always_comb begin
        attr.gran      = gran_i;
        attr.grow_down = grow_down_i;
        attr.big       = big_i;
        attr.flat64    = flat64_i;
    end

    seg_lim_scale #(
        .RAW_W   (RAW_W),
        .ADDR_W  (ADDR_W),
        .GRAN_SH (GRAN_SH)
    ) u_scale (
        .raw_lim (raw_lim_i),
        .gran    (gran_i),
        .eff_lim (lim_w)
    );

    seg_lim_range #(
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W),
        .SMALL_W (SMALL_W)
    ) u_range (
        .offset    (offset_i),
        .acc_bytes (acc_bytes_i),
        .eff_lim   (lim_w),
        .attr      (attr),
        .fault     (fault_w)
    );

    seg_lim_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_i),
        .capture   (capture),
        .rsp_valid (rsp_valid_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            lim_q   <= '0;
        end else if (capture) begin
            fault_q <= fault_w;
            lim_q   <= lim_w;
        end
    end

    always_comb begin
        fault_o     = fault_q;
        eff_limit_o = lim_q;
    end

    AST_FLAT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && flat64_i |=> !fault_o); // R6
    AST_GRAN_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && gran_i |=> (&eff_limit_o[GRAN_SH-1:0])); // R2
    AST_FINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !gran_i |=> eff_limit_o[RAW_W-1:0] == $past(raw_lim_i)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(fault_o) && $stable(eff_limit_o)); // R9
    AST_UP_END_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !flat64_i && !grow_down_i && (offset_i > lim_w) |=> fault_o); // R3

endmodule

// File: tb/seg_lim_chk_tb_top.sv
module seg_lim_chk_tb_top;

    typedef struct {
        logic        fault;
        logic [31:0] lim;
        string       tag;
        string       ltag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [19:0] raw_lim_i = '0;
    logic        gran_i = 1'b0;
    logic        grow_down_i = 1'b0;
    logic        big_i = 1'b0;
    logic [3:0]  acc_bytes_i = '0;
    logic        flat64_i = 1'b0;
    logic [31:0] offset_i = '0;
    logic        rsp_valid_o;
    logic        fault_o;
    logic [31:0] eff_limit_o;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #10 clk = ~clk;

    seg_lim_chk dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .raw_lim_i(raw_lim_i),
        .gran_i(gran_i), .grow_down_i(grow_down_i), .big_i(big_i),
        .acc_bytes_i(acc_bytes_i), .flat64_i(flat64_i), .offset_i(offset_i),
        .rsp_valid_o(rsp_valid_o), .fault_o(fault_o), .eff_limit_o(eff_limit_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected results from the requirements (R1..R7)
    function automatic exp_t model(input logic [19:0] raw, input logic g, input logic dn,
                                   input logic bg, input logic [3:0] sz, input logic fl,
                                   input logic [31:0] off, input string tag);
        exp_t e;
        longint unsigned lim, last, top, n;
        lim  = g ? ((longint'(raw) << 12) | 64'hFFF) : longint'(raw);
        n    = (sz == 0) ? 1 : longint'(sz);
        last = longint'(off) + n - 1;
        top  = bg ? 64'hFFFF_FFFF : 64'hFFFF;
        if (fl)       e.fault = 1'b0;
        else if (dn)  e.fault = (longint'(off) <= lim) || (last > top);
        else          e.fault = (last > lim);
        e.lim  = lim[31:0];
        e.tag  = tag;
        e.ltag = g ? "R2" : "R1";
        return e;
    endfunction

    task automatic drive(input logic [19:0] raw, input logic g, input logic dn, input logic bg,
                         input logic [3:0] sz, input logic fl, input logic [31:0] off,
                         input string tag);
        raw_lim_i = raw; gran_i = g; grow_down_i = dn; big_i = bg;
        acc_bytes_i = sz; flat64_i = fl; offset_i = off; req_i = 1'b1;
        last_exp = model(raw, g, dn, bg, sz, fl, off, tag);
        sb_q.push_back(last_exp);
        @(negedge clk);
    endtask

    task automatic go_idle(input int cycles);
        req_i = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            offset_i  = $urandom;
            raw_lim_i = 20'($urandom);
            gran_i    = ~gran_i;
            @(negedge clk);
        end
    endtask

    // Monitor: compares each presented result against the queue head
    always @(negedge clk) begin
        if (rst_n && rsp_valid_o) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R8 actual=unexpected result expected=none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {31'b0, fault_o}, {31'b0, e.fault});
                check(e.ltag, eff_limit_o, e.lim);
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset fault", {31'b0, fault_o}, 32'd0);
        check("R9 reset limit", eff_limit_o, 32'd0);
        check("R9 reset valid", {31'b0, rsp_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: single strobe gives a one-cycle valid pulse
        drive(20'h00100, 0, 0, 0, 4'd1, 0, 32'h0000_0100, "R3");
        check("R8 valid after strobe", {31'b0, rsp_valid_o}, 32'd1);
        go_idle(1);
        check("R8 valid drops", {31'b0, rsp_valid_o}, 32'd0);
        go_idle(2);
        check("R9 hold fault", {31'b0, fault_o}, {31'b0, last_exp.fault});
        check("R9 hold limit", eff_limit_o, last_exp.lim);

        // R3 upward limit boundaries
        drive(20'h00100, 0, 0, 0, 4'd1, 0, 32'h0000_0101, "R3");
        drive(20'h00100, 0, 0, 0, 4'd4, 0, 32'h0000_00FD, "R3");
        drive(20'h00100, 0, 0, 0, 4'd4, 0, 32'h0000_00FE, "R3");
        // R1 / R2 scaling
        drive(20'hFFFFF, 0, 0, 0, 4'd1, 0, 32'h000F_FFFF, "R1");
        drive(20'h00003, 1, 0, 0, 4'd1, 0, 32'h0000_3FFF, "R2");
        drive(20'h00003, 1, 0, 0, 4'd2, 0, 32'h0000_3FFF, "R2");
        drive(20'hFFFFF, 1, 0, 0, 4'd8, 0, 32'hFFFF_FFF8, "R2");
        // R7 wrap and zero size
        drive(20'hFFFFF, 1, 0, 0, 4'd8, 0, 32'hFFFF_FFF9, "R7");
        drive(20'h00010, 0, 0, 0, 4'd0, 0, 32'h0000_0010, "R7");
        drive(20'h00010, 1, 1, 1, 4'd2, 0, 32'hFFFF_FFFF, "R7");
        // R4 / R5 downward segments
        drive(20'h00010, 0, 1, 0, 4'd1, 0, 32'h0000_0010, "R5");
        drive(20'h00010, 0, 1, 0, 4'd1, 0, 32'h0000_0011, "R4");
        drive(20'h00010, 0, 1, 0, 4'd2, 0, 32'h0000_FFFF, "R4");
        drive(20'h00010, 0, 1, 0, 4'd2, 0, 32'h0000_FFFE, "R4");
        drive(20'h00010, 0, 1, 1, 4'd2, 0, 32'h0000_FFFF, "R4");
        drive(20'h00010, 0, 1, 1, 4'd4, 0, 32'hFFFF_FFFC, "R4");
        drive(20'h00002, 1, 1, 1, 4'd1, 0, 32'h0000_2FFF, "R5");
        // R6 flat mode bypass
        drive(20'h00000, 0, 0, 0, 4'd8, 1, 32'hFFFF_FFFF, "R6");
        drive(20'h00010, 0, 1, 0, 4'd1, 1, 32'h0000_0010, "R6");
        go_idle(2);

        // Mixed traffic near the boundaries
        for (int k = 0; k < 300; k++) begin
            logic [19:0] r;
            logic g, dn, bg, fl;
            logic [31:0] lim, off;
            string t;
            r  = 20'($urandom);
            g  = 1'($urandom);
            dn = 1'($urandom);
            bg = 1'($urandom);
            fl = ($urandom_range(0, 7) == 0);
            lim = g ? {r, 12'hFFF} : {12'h0, r};
            case ($urandom_range(0, 3))
                0: off = lim + 32'($urandom_range(0, 4)) - 32'd2;
                1: off = 32'h0000_FFFF - 32'($urandom_range(0, 5));
                2: off = 32'hFFFF_FFFF - 32'($urandom_range(0, 7));
                default: off = $urandom;
            endcase
            t = fl ? "R6" : (dn ? "R4" : "R3");
            drive(r, g, dn, bg, 4'($urandom_range(0, 8)), fl, off, t);
            if ($urandom_range(0, 3) == 0) go_idle(1);
        end
        go_idle(3);
        check("R8 all results seen", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule